// File: doc/BRIEF.md
# LCD Controller Register Interface

This block is the programming front end of a colour LCD controller. It sits on a simple 32-bit peripheral bus and decodes a 4 KB window, addressed in bytes and used as words. It holds the panel timing words, the two frame base addresses, the control word, the interrupt mask and the raw interrupt status. It also serves a read-only identification area and passes palette-window accesses to a separate palette store. From two of the timing words it derives the frame geometry, which it hands to the downstream pixel logic together with the enable flag, the colour depth code and the ordering flags.

Raw interrupt status bits are set by single-cycle event pulses from the pixel logic. Software clears them by writing ones to a clear register. A single interrupt line is the OR of the status bits that the mask lets through. A static strap input selects an alternate map in which the control and interrupt-mask words swap places.

Top module: `lcd_regif`

## Requirements
- R1: After reset all stored registers read as zero, the derived geometry is 16 pixels by 1 line, and disp_en, geom_pulse and irq are low.
- R2: Word offsets 0 to 3 (byte 0x00 to 0x0C) read back the timing words written there. Offset 4 (0x10) holds the upper base and offset 5 (0x14) the lower base. Offsets 11 (0x2C) and 12 (0x30) read the upper and lower base respectively.
- R3: line_pixels equals 16 times (timing word 0 bits [7:2] plus one). frame_lines equals timing word 1 bits [9:0] plus one. The other bits of those words have no effect. Both outputs take the new value in the cycle after the write.
- R4: geom_pulse is high for exactly the one cycle after a write to word offset 0 or 1, and it stays low after writes to any other offset.
- R5: In the control word, bit 0 is enable, bits [3:1] are the colour depth code, bit 8 is BGR order, bit 9 is big-endian byte order, bit 10 is big-endian pixel order and bit 11 is power. disp_en is 1 only when bits 0 and 11 are both 1.
- R6: With variant_swap low, word offset 6 (0x18) is the interrupt mask and offset 7 (0x1C) is control. With variant_swap high the two swap, for both reads and writes.
- R7: A 1 on evt_set bit i sets raw status bit i. Offset 8 (0x20) reads the raw status, offset 9 (0x24) reads raw AND mask, and irq is high when any masked bit is set.
- R8: A write to offset 10 (0x28) clears each raw status bit whose written bit is 1. An event pulse in the same cycle wins over the clear.
- R9: Byte offsets 0xFE0 to 0xFFC read one identification byte per word, in the order 0x10, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R10: An access to byte offsets 0x200 to 0x3FF raises pal_req, with pal_idx = (offset - 0x200) >> 2 and pal_we equal to the write flag. A read there returns pal_rdata.
- R11: Unmapped offsets read as zero, and writes to them change no register and the palette.
- R12: Read data appears on bus_rdata after the clock edge that samples the read and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| variant_swap | input | 1 | Strap: swap the control and mask offsets |
| bus_valid | input | 1 | Bus access in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| evt_set | input | 5 | Event pulses setting raw status bits |
| irq | output | 1 | Interrupt, OR of masked status |
| pal_req | output | 1 | Palette access strobe |
| pal_we | output | 1 | Palette write enable |
| pal_idx | output | 7 | Palette word index |
| pal_wdata | output | 32 | Palette write data |
| pal_rdata | input | 32 | Palette read data, same cycle |
| disp_en | output | 1 | Enable and power both set |
| color_depth | output | 3 | Colour depth code |
| bgr_order | output | 1 | BGR colour order |
| be_byte | output | 1 | Big-endian byte order |
| be_pixel | output | 1 | Big-endian pixel order in a byte |
| line_pixels | output | 11 | Active pixels per line |
| frame_lines | output | 11 | Lines per frame |
| geom_pulse | output | 1 | One-cycle pulse on a geometry write |

## Verification
Register outputs (control flags, geometry, irq) change at the edge that samples the write or event, so they are due one cycle after the stimulus. geom_pulse is high in that same cycle and low one cycle later. Read data also lands one edge after the read is presented. The bench drives every access on a falling edge and samples on the next falling edge, after exactly one rising edge, so each check looks at the cycle in which its result is due. Pulse-width checks sample one further cycle to confirm the pulse has ended.

// File: rtl/lcd_regif_pkg.sv
// Shared types and constants for the LCD register interface.
// Assumes a 4 KB byte-addressed window with word-aligned accesses.
package lcd_regif_pkg;

    localparam int ADDR_W     = 12;
    localparam int PAL_IDX_W  = 7;
    localparam int HFIELD_W   = 6;
    localparam int VFIELD_W   = 10;
    localparam int PIX_W      = HFIELD_W + 1 + 4;
    localparam int LINE_W     = VFIELD_W + 1;

    // control bit positions, decoded by the pixel logic
    localparam int CB_EN   = 0;
    localparam int CB_DLO  = 1;
    localparam int CB_BGR  = 8;
    localparam int CB_BEB  = 9;
    localparam int CB_BEP  = 10;
    localparam int CB_PWR  = 11;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_TIM0, SEL_TIM1, SEL_TIM2, SEL_TIM3,
        SEL_UPB, SEL_LPB, SEL_MASK, SEL_CTRL, SEL_RIS,
        SEL_MIS, SEL_ICR, SEL_UPC, SEL_LPC, SEL_PAL, SEL_ID
    } reg_sel_e;

    // identification byte for word i of the ID area
    function automatic logic [7:0] id_byte(input logic [2:0] i);
        case (i)
            3'd0:    return 8'h10;
            3'd1:    return 8'h11;
            3'd2:    return 8'h04;
            3'd3:    return 8'h00;
            3'd4:    return 8'h0D;
            3'd5:    return 8'hF0;
            3'd6:    return 8'h05;
            default: return 8'hB1;
        endcase
    endfunction

endpackage

// File: rtl/lcd_addr_decode.sv
// Address decoder: maps a byte offset to a register select.
// Assumes the strap is static; it only swaps the mask and control words.
module lcd_addr_decode
    import lcd_regif_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              swap,
    output reg_sel_e          sel
);

    // pick the register selected by the word offset
    always_comb begin
        sel = SEL_NONE;
        if (addr[ADDR_W-1:9] == 3'b001) begin
            sel = SEL_PAL;
        end else if (addr[ADDR_W-1:5] == 7'h7F) begin
            sel = SEL_ID;
        end else if (addr[ADDR_W-1:6] == '0) begin
            case (addr[5:2])
                4'd0:  sel = SEL_TIM0;
                4'd1:  sel = SEL_TIM1;
                4'd2:  sel = SEL_TIM2;
                4'd3:  sel = SEL_TIM3;
                4'd4:  sel = SEL_UPB;
                4'd5:  sel = SEL_LPB;
                4'd6:  sel = swap ? SEL_CTRL : SEL_MASK;
                4'd7:  sel = swap ? SEL_MASK : SEL_CTRL;
                4'd8:  sel = SEL_RIS;
                4'd9:  sel = SEL_MIS;
                4'd10: sel = SEL_ICR;
                4'd11: sel = SEL_UPC;
                4'd12: sel = SEL_LPC;
                default: sel = SEL_NONE;
            endcase
        end
    end

endmodule

// File: rtl/lcd_geom.sv
// Geometry decoder: derives pixels per line and lines per frame
// from the packed timing fields. Purely combinational.
module lcd_geom
    import lcd_regif_pkg::*;
#(
    parameter int DATA_W = 32
)(
    input  logic [DATA_W-1:0] tim0,
    input  logic [DATA_W-1:0] tim1,
    output logic [PIX_W-1:0]  line_pixels,
    output logic [LINE_W-1:0] frame_lines
);

    logic [HFIELD_W:0] hcount;

    // line length is 16 pixels per unit of the horizontal field
    always_comb begin
        hcount      = {1'b0, tim0[HFIELD_W+1:2]} + 1'b1;
        line_pixels = {hcount, 4'b0000};
        frame_lines = {1'b0, tim1[VFIELD_W-1:0]} + 1'b1;
    end

endmodule

// File: rtl/lcd_irq_status.sv
// Interrupt status: raw bits set by event pulses, cleared by
// write-one-to-clear; a set in the same cycle wins.
module lcd_irq_status #(
    parameter int NUM_IRQ = 5
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] evt_set,
    input  logic               clr_we,
    input  logic [NUM_IRQ-1:0] clr_bits,
    input  logic [NUM_IRQ-1:0] mask,
    output logic [NUM_IRQ-1:0] ris,
    output logic               irq
);

    logic [NUM_IRQ-1:0] clr_eff;

    // gate the clear pattern with its strobe
    always_comb clr_eff = clr_we ? clr_bits : '0;

    // raw status register
    always_ff @(posedge clk) begin
        if (!rst_n) ris <= '0;
        else        ris <= (ris & ~clr_eff) | evt_set;
    end

    // interrupt line from masked status
    always_comb irq = |(ris & mask);

endmodule

// File: rtl/lcd_regif.sv
// LCD controller register interface (top). Holds timing, base, control
// and mask words, serves ID bytes, forwards palette accesses and drives
// geometry and mode flags to the pixel logic.
// Assumes single-cycle bus accesses and a same-cycle palette read port.
module lcd_regif
    import lcd_regif_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int NUM_IRQ = 5
)(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 variant_swap,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [NUM_IRQ-1:0]   evt_set,
    output logic                 irq,
    output logic                 pal_req,
    output logic                 pal_we,
    output logic [PAL_IDX_W-1:0] pal_idx,
    output logic [DATA_W-1:0]    pal_wdata,
    input  logic [DATA_W-1:0]    pal_rdata,
    output logic                 disp_en,
    output logic [2:0]           color_depth,
    output logic                 bgr_order,
    output logic                 be_byte,
    output logic                 be_pixel,
    output logic [PIX_W-1:0]     line_pixels,
    output logic [LINE_W-1:0]    frame_lines,
    output logic                 geom_pulse
);

    localparam int NUM_TIM = 4;

    reg_sel_e            sel;
    logic                wr, rd;
    logic                tim_hit;
    logic [DATA_W-1:0]   tim_q [NUM_TIM];
    logic [DATA_W-1:0]   upb_q, lpb_q, ctrl_q;
    logic [NUM_IRQ-1:0]  mask_q;
    logic [NUM_IRQ-1:0]  ris_w;
    logic [DATA_W-1:0]   rd_next;
    logic                geom_q;

    lcd_addr_decode u_dec (
        .addr (bus_addr),
        .swap (variant_swap),
        .sel  (sel)
    );

    // access strobes
    always_comb begin
        wr      = bus_valid &&  bus_write;
        rd      = bus_valid && !bus_write;
        tim_hit = wr && (sel == SEL_TIM0 || sel == SEL_TIM1 ||
                         sel == SEL_TIM2 || sel == SEL_TIM3);
    end

    // one register per timing word
    for (genvar g = 0; g < NUM_TIM; g++) begin : g_tim
        always_ff @(posedge clk) begin
            if (!rst_n)                                  tim_q[g] <= '0;
            else if (tim_hit && bus_addr[3:2] == 2'(g))  tim_q[g] <= bus_wdata;
        end
    end

    // base, control and mask registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upb_q  <= '0;
            lpb_q  <= '0;
            ctrl_q <= '0;
            mask_q <= '0;
        end else if (wr) begin
            case (sel)
                SEL_UPB:  upb_q  <= bus_wdata;
                SEL_LPB:  lpb_q  <= bus_wdata;
                SEL_CTRL: ctrl_q <= bus_wdata;
                SEL_MASK: mask_q <= bus_wdata[NUM_IRQ-1:0];
                default:  ;
            endcase
        end
    end

    // geometry-changed pulse
    always_ff @(posedge clk) begin
        if (!rst_n) geom_q <= 1'b0;
        else        geom_q <= wr && (sel == SEL_TIM0 || sel == SEL_TIM1);
    end

    lcd_irq_status #(.NUM_IRQ(NUM_IRQ)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_set  (evt_set),
        .clr_we   (wr && sel == SEL_ICR),
        .clr_bits (bus_wdata[NUM_IRQ-1:0]),
        .mask     (mask_q),
        .ris      (ris_w),
        .irq      (irq)
    );

    lcd_geom #(.DATA_W(DATA_W)) u_geom (
        .tim0        (tim_q[0]),
        .tim1        (tim_q[1]),
        .line_pixels (line_pixels),
        .frame_lines (frame_lines)
    );

    // read multiplexer
    always_comb begin
        case (sel)
            SEL_TIM0: rd_next = tim_q[0];
            SEL_TIM1: rd_next = tim_q[1];
            SEL_TIM2: rd_next = tim_q[2];
            SEL_TIM3: rd_next = tim_q[3];
            SEL_UPB,
            SEL_UPC:  rd_next = upb_q;
            SEL_LPB,
            SEL_LPC:  rd_next = lpb_q;
            SEL_CTRL: rd_next = ctrl_q;
            SEL_MASK: rd_next = DATA_W'(mask_q);
            SEL_RIS:  rd_next = DATA_W'(ris_w);
            SEL_MIS:  rd_next = DATA_W'(ris_w & mask_q);
            SEL_PAL:  rd_next = pal_rdata;
            SEL_ID:   rd_next = DATA_W'(id_byte(bus_addr[4:2]));
            default:  rd_next = '0;
        endcase
    end

    // registered read data, held between reads
    always_ff @(posedge clk) begin
        if (!rst_n)  bus_rdata <= '0;
        else if (rd) bus_rdata <= rd_next;
    end

    // palette port forwarding
    always_comb begin
        pal_req   = bus_valid && sel == SEL_PAL;
        pal_we    = bus_write;
        pal_idx   = bus_addr[8:2];
        pal_wdata = bus_wdata;
    end

    // mode flags to the pixel logic
    always_comb begin
        disp_en     = ctrl_q[CB_EN] && ctrl_q[CB_PWR];
        color_depth = ctrl_q[CB_DLO+2:CB_DLO];
        bgr_order   = ctrl_q[CB_BGR];
        be_byte     = ctrl_q[CB_BEB];
        be_pixel    = ctrl_q[CB_BEP];
        geom_pulse  = geom_q;
    end

endmodule

// File: rtl/lcd_regif_chk.sv
// Checker for lcd_regif: temporal properties over bus writes and
// the outputs they drive. Bound to every instance of the top.
module lcd_regif_chk
    import lcd_regif_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int NUM_IRQ = 5
)(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 variant_swap,
    input logic                 bus_valid,
    input logic                 bus_write,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [DATA_W-1:0]    bus_wdata,
    input logic [NUM_IRQ-1:0]   evt_set,
    input logic [NUM_IRQ-1:0]   ris,
    input logic                 disp_en,
    input logic [2:0]           color_depth,
    input logic [PIX_W-1:0]     line_pixels,
    input logic                 geom_pulse,
    input logic                 pal_req,
    input logic [PAL_IDX_W-1:0] pal_idx
);

    logic wr_any, wr_geom, wr_t0, wr_ctrl, wr_icr;
    logic [PIX_W-1:0] exp_pix;

    always_comb begin
        wr_any  = bus_valid && bus_write;
        wr_geom = wr_any && bus_addr[ADDR_W-1:3] == '0;
        wr_t0   = wr_any && bus_addr[ADDR_W-1:2] == '0;
        wr_ctrl = wr_any && bus_addr[ADDR_W-1:2] == (variant_swap ? 10'd6 : 10'd7);
        wr_icr  = wr_any && bus_addr[ADDR_W-1:2] == 10'd10;
        exp_pix = PIX_W'((7'(bus_wdata[7:2]) + 7'd1) * 16);
    end

    assert_geom_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_geom |=> geom_pulse);

    assert_geom_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        geom_pulse |-> $past(wr_geom));

    assert_line_pixels_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_t0 |=> line_pixels == $past(exp_pix));

    // also covers R6: the control offset follows the strap
    assert_ctrl_fields_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> (disp_en == $past(bus_wdata[0] && bus_wdata[11])) &&
                    (color_depth == $past(bus_wdata[3:1])));

    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_icr |=> (ris & $past(bus_wdata[NUM_IRQ-1:0] & ~evt_set)) == '0);

    assert_pal_route_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pal_req |-> (bus_addr[ADDR_W-1:9] == 3'b001) && (pal_idx == bus_addr[8:2]));

endmodule

bind lcd_regif lcd_regif_chk #(.DATA_W(DATA_W), .NUM_IRQ(NUM_IRQ)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .variant_swap (variant_swap),
    .bus_valid    (bus_valid),
    .bus_write    (bus_write),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .evt_set      (evt_set),
    .ris          (ris_w),
    .disp_en      (disp_en),
    .color_depth  (color_depth),
    .line_pixels  (line_pixels),
    .geom_pulse   (geom_pulse),
    .pal_req      (pal_req),
    .pal_idx      (pal_idx)
);

// File: tb/tb_lcd_regif.sv
// Directed bench for lcd_regif: one task per scenario.
module tb_lcd_regif;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        variant_swap = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [4:0]  evt_set = '0;
    logic        irq;
    logic        pal_req, pal_we;
    logic [6:0]  pal_idx;
    logic [31:0] pal_wdata, pal_rdata;
    logic        disp_en, bgr_order, be_byte, be_pixel, geom_pulse;
    logic [2:0]  color_depth;
    logic [10:0] line_pixels, frame_lines;

    logic [31:0] pal_mem [128];
    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    lcd_regif dut (
        .clk(clk), .rst_n(rst_n), .variant_swap(variant_swap),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_set(evt_set),
        .irq(irq), .pal_req(pal_req), .pal_we(pal_we), .pal_idx(pal_idx),
        .pal_wdata(pal_wdata), .pal_rdata(pal_rdata), .disp_en(disp_en),
        .color_depth(color_depth), .bgr_order(bgr_order), .be_byte(be_byte),
        .be_pixel(be_pixel), .line_pixels(line_pixels),
        .frame_lines(frame_lines), .geom_pulse(geom_pulse)
    );

    // palette store model
    assign pal_rdata = pal_mem[pal_idx];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 128; i++) pal_mem[i] <= '0;
        end else if (pal_req && pal_we) begin
            pal_mem[pal_idx] <= pal_wdata;
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog all: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d,
                      input logic [4:0] e = '0);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        evt_set = e;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; evt_set = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a,
                          input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, $sformatf("read %h", a), v, exp);
    endtask

    task automatic pulse_evt(input logic [4:0] e);
        @(negedge clk);
        evt_set = e;
        @(negedge clk);
        evt_set = '0;
    endtask

    task automatic t_reset;
        for (int i = 0; i < 13; i++) rd_chk("R1", 12'(i * 4), 32'h0);
        check("R1", "line_pixels", 32'(line_pixels), 32'd16);
        check("R1", "frame_lines", 32'(frame_lines), 32'd1);
        check("R1", "disp_en", 32'(disp_en), 32'd0);
        check("R1", "irq", 32'(irq), 32'd0);
        check("R1", "geom_pulse", 32'(geom_pulse), 32'd0);
    endtask

    task automatic t_geometry;
        wr(12'h000, 32'h0000_00FC);
        check("R4", "pulse after t0", 32'(geom_pulse), 32'd1);
        check("R3", "pixels max", 32'(line_pixels), 32'd1024);
        @(negedge clk);
        check("R4", "pulse one cycle", 32'(geom_pulse), 32'd0);
        wr(12'h000, 32'h0000_0028);
        check("R3", "pixels 176", 32'(line_pixels), 32'd176);
        wr(12'h000, 32'hFFFF_FF03);
        check("R3", "pixels other bits", 32'(line_pixels), 32'd16);
        wr(12'h004, 32'h0000_03FF);
        check("R4", "pulse after t1", 32'(geom_pulse), 32'd1);
        check("R3", "lines max", 32'(frame_lines), 32'd1024);
        wr(12'h004, 32'h0000_00EF);
        check("R3", "lines 240", 32'(frame_lines), 32'd240);
        wr(12'h004, 32'hFFFF_FC00);
        check("R3", "lines other bits", 32'(frame_lines), 32'd1);
        wr(12'h008, 32'h1234_5678);
        check("R4", "no pulse t2", 32'(geom_pulse), 32'd0);
        wr(12'h010, 32'h1);
        check("R4", "no pulse base", 32'(geom_pulse), 32'd0);
    endtask

    task automatic t_regmap;
        wr(12'h000, 32'hA5A5_00FC);
        wr(12'h004, 32'h5A5A_01DF);
        wr(12'h008, 32'h1111_2222);
        wr(12'h00C, 32'h3333_4444);
        wr(12'h010, 32'h8000_1000);
        wr(12'h014, 32'h8004_0000);
        rd_chk("R2", 12'h000, 32'hA5A5_00FC);
        rd_chk("R2", 12'h004, 32'h5A5A_01DF);
        rd_chk("R2", 12'h008, 32'h1111_2222);
        rd_chk("R2", 12'h00C, 32'h3333_4444);
        rd_chk("R2", 12'h010, 32'h8000_1000);
        rd_chk("R2", 12'h014, 32'h8004_0000);
        rd_chk("R2", 12'h02C, 32'h8000_1000);
        rd_chk("R2", 12'h030, 32'h8004_0000);
    endtask

    task automatic t_control;
        wr(12'h01C, 32'h0000_0001);
        check("R5", "enable without power", 32'(disp_en), 32'd0);
        wr(12'h01C, 32'h0000_0800);
        check("R5", "power without enable", 32'(disp_en), 32'd0);
        wr(12'h01C, 32'h0000_080B);
        check("R5", "enable and power", 32'(disp_en), 32'd1);
        check("R5", "depth 5", 32'(color_depth), 32'd5);
        check("R5", "flags clear", {29'd0, bgr_order, be_byte, be_pixel}, 32'd0);
        wr(12'h01C, 32'h0000_0300);
        check("R5", "bgr+be_byte", {29'd0, bgr_order, be_byte, be_pixel}, 32'd6);
        wr(12'h01C, 32'h0000_0C0F);
        check("R5", "be_pixel", {29'd0, bgr_order, be_byte, be_pixel}, 32'd1);
        check("R5", "depth 7", 32'(color_depth), 32'd7);
        rd_chk("R5", 12'h01C, 32'h0000_0C0F);
    endtask

    task automatic t_variant;
        variant_swap = 1'b1;
        wr(12'h018, 32'h0000_0801);
        check("R6", "ctrl at 6", 32'(disp_en), 32'd1);
        wr(12'h01C, 32'h0000_001F);
        rd_chk("R6", 12'h018, 32'h0000_0801);
        rd_chk("R6", 12'h01C, 32'h0000_001F);
        variant_swap = 1'b0;
        rd_chk("R6", 12'h018, 32'h0000_001F);
        rd_chk("R6", 12'h01C, 32'h0000_0801);
    endtask

    task automatic t_irq;
        wr(12'h018, 32'h0000_0004);
        pulse_evt(5'h01);
        check("R7", "irq masked out", 32'(irq), 32'd0);
        rd_chk("R7", 12'h020, 32'h1);
        rd_chk("R7", 12'h024, 32'h0);
        pulse_evt(5'h04);
        check("R7", "irq raised", 32'(irq), 32'd1);
        rd_chk("R7", 12'h024, 32'h4);
        rd_chk("R7", 12'h020, 32'h5);
    endtask

    task automatic t_clear;
        wr(12'h028, 32'h0000_0004);
        check("R8", "irq after clear", 32'(irq), 32'd0);
        rd_chk("R8", 12'h020, 32'h1);
        wr(12'h028, 32'h0000_001F, 5'h02);
        rd_chk("R8", 12'h020, 32'h2);
        wr(12'h028, 32'h0000_0002);
        rd_chk("R8", 12'h020, 32'h0);
    endtask

    task automatic t_id;
        logic [7:0] exp_id [8] = '{8'h10, 8'h11, 8'h04, 8'h00,
                                   8'h0D, 8'hF0, 8'h05, 8'hB1};
        for (int i = 0; i < 8; i++)
            rd_chk("R9", 12'(12'hFE0 + i * 4), 32'(exp_id[i]));
    endtask

    task automatic t_palette;
        wr(12'h200, 32'hCAFE_0001);
        check("R10", "pal entry 0", pal_mem[0], 32'hCAFE_0001);
        wr(12'h3FC, 32'hBEEF_007F);
        check("R10", "pal entry 127", pal_mem[127], 32'hBEEF_007F);
        wr(12'h284, 32'h0000_0A5A);
        check("R10", "pal entry 33", pal_mem[33], 32'h0000_0A5A);
        rd_chk("R10", 12'h200, 32'hCAFE_0001);
        rd_chk("R10", 12'h3FC, 32'hBEEF_007F);
    endtask

    task automatic t_unmapped;
        wr(12'h034, 32'hFFFF_FFFF);
        rd_chk("R11", 12'h034, 32'h0);
        wr(12'h400, 32'hDEAD_DEAD);
        check("R11", "pal untouched by 0x400", pal_mem[0], 32'hCAFE_0001);
        wr(12'h1FC, 32'hDEAD_DEAD);
        check("R11", "pal untouched by 0x1FC", pal_mem[127], 32'hBEEF_007F);
        wr(12'h048, 32'hDEAD_DEAD);
        rd_chk("R11", 12'h100, 32'h0);
        rd_chk("R11", 12'h008, 32'h1111_2222);
        rd_chk("R11", 12'h010, 32'h8000_1000);
    endtask

    task automatic t_latency;
        logic [31:0] v;
        rd(12'h00C, v);
        check("R12", "read data", v, 32'h3333_4444);
        wr(12'h008, 32'h0);
        check("R12", "held after write", bus_rdata, 32'h3333_4444);
        @(negedge clk);
        check("R12", "held when idle", bus_rdata, 32'h3333_4444);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_geometry();
        t_regmap();
        t_control();
        t_variant();
        t_irq();
        t_clear();
        t_id();
        t_palette();
        t_unmapped();
        t_latency();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule